// File: doc/BRIEF.md
# Dual-Mode Interrupt Request Front End

This block gathers the interrupt sources of a two-channel serial controller into one active-low request line for a host processor. Each channel contributes four event flags: receive data ready, transmit holding ready, a status change and one spare event. An 8-bit enable mask chooses which of them can pull the request low. Receiver error flags (overrun, parity, framing) never reach the request line. The host sees them only by reading a per-channel status register.

The block serves the host in one of two ways. After reset it runs in plain mode. In plain mode the host locates its handler on its own and never has to acknowledge. A command written by the host moves the block into vectored mode. In vectored mode, while the acknowledge strobe is low and a request is pending, the block puts its programmable 8-bit vector on the data bus and raises the drive enable. A second command returns it to plain mode and leaves the mask and vector untouched. The block has no bidirectional pin. An external pad cell turns the drive enable into the high-impedance control.

Top module: `irq_front`

## Requirements
- R1: After reset the block is in plain mode (mode bit 0), the mask reads 0x00, the vector reads 0x0F, irq_n is 1 and bus_oe is 0.
- R2: The block enters vectored mode only through a write of 0x01 to address 2. The mode then reads back as bit 0 of address 2.
- R3: In vectored mode, while iack_n is 0 and irq_n is 0, bus_oe is 1 and bus_data equals the vector register.
- R4: bus_oe is 0 in plain mode, when iack_n is 1, and when no enabled source is pending. irq_n never waits for an acknowledge.
- R5: irq_n is 0 in the same cycle that any bit of src_pend AND mask is 1. It is 1 as soon as none is. Masked or idle sources have no effect.
- R6: The mask is written and read at address 0, and a mask write governs irq_n from the clock edge that stores it.
- R7: The vector is written and read at address 1.
- R8: A write of 0x02 to address 2 returns the block to plain mode and keeps the mask and vector. Any other value written to address 2 leaves the mode unchanged.
- R9: rx_err never affects irq_n or bus_oe. Channel c's status reads at address 3+c with bit 7 = 0, bits 6:4 = {framing, parity, overrun} = rx_err[3c+2:3c], and bits 3:0 = src_pend[4c+3:4c] unmasked.
- R10: Reads of addresses 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | 8 | Raw source flags, channel c at bits 4c+3:4c |
| rx_err | input | 6 | Receiver error flags, channel c at bits 3c+2:3c |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| iack_n | input | 1 | Active-low interrupt acknowledge strobe |
| irq_n | output | 1 | Active-low interrupt request |
| bus_data | output | 8 | Vector driven during acknowledge |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
If the mode flag were wrong, the error would show on bus_oe during the first acknowledge cycle that follows a pending request. A wrong flag would either drive the vector in plain mode or leave the bus floating in vectored mode. If the mask or the vector were corrupted, the fault would appear on irq_n in the same cycle as the next pending source, or in bus_data during the next acknowledge. Both registers can also be read back at once. An error flag that leaks into the request path would move irq_n in the cycle the flag rises while every enabled source stays idle, so the bench holds the sources still while it toggles the errors.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {MODE_PLAIN = 1'b0, MODE_VECT = 1'b1} svc_mode_e;

   localparam int unsigned ADDR_MASK   = 0;
   localparam int unsigned ADDR_VECT   = 1;
   localparam int unsigned ADDR_CMD    = 2;
   localparam int unsigned ADDR_STAT0  = 3;

   localparam logic [7:0] CMD_GO_VECT  = 8'h01;
   localparam logic [7:0] CMD_GO_PLAIN = 8'h02;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
   import irq_pkg::*;
#(
   parameter int unsigned     DATA_W  = 8,
   parameter int unsigned     ADDR_W  = 3,
   parameter int unsigned     N_SRC   = 8,
   parameter logic [DATA_W-1:0] VEC_RST = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [N_SRC-1:0]  mask_q,
   output logic [DATA_W-1:0] vec_q,
   output svc_mode_e         mode_q
);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
   localparam logic [ADDR_W-1:0] A_VECT = ADDR_W'(ADDR_VECT);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADDR_CMD);
   localparam logic [DATA_W-1:0] C_VECT = DATA_W'(CMD_GO_VECT);
   localparam logic [DATA_W-1:0] C_PLN  = DATA_W'(CMD_GO_PLAIN);

   logic cmd_wr;
   assign cmd_wr = wr_en && (wr_addr == A_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         vec_q  <= VEC_RST;
         mode_q <= MODE_PLAIN;
      end else if (wr_en) begin
         case (wr_addr)
            A_MASK: mask_q <= wr_data[N_SRC-1:0];
            A_VECT: vec_q  <= wr_data;
            A_CMD: begin
               if (wr_data == C_VECT)     mode_q <= MODE_VECT;
               else if (wr_data == C_PLN) mode_q <= MODE_PLAIN;
            end
            default: ;
         endcase
      end
   end

   logic is_vect;
   assign is_vect = (mode_q == MODE_VECT);

   assert_mode_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_vect) |-> $past(cmd_wr && wr_data == C_VECT));

   assert_revert_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(is_vect) |-> ($stable(mask_q) && $stable(vec_q)));

   assert_bad_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wr && wr_data != C_VECT && wr_data != C_PLN) |-> $stable(is_vect));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
   parameter int unsigned N_SRC   = 8,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_pend,
   input  logic [N_SRC-1:0] mask_q,
   output logic             irq_n
);
   logic [N_SRC-1:0] live;
   logic             any_live;

   for (genvar i = 0; i < N_SRC; i++) begin : g_gate
      assign live[i] = src_pend[i] & mask_q[i];
   end
   assign any_live = |live;

   if (REG_IRQ) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b1;
         else        irq_q <= ~any_live;
      end
      assign irq_n = irq_q;
   end else begin : g_comb
      assign irq_n = ~any_live;
   end
endmodule

// File: rtl/irq_vec_drive.sv
module irq_vec_drive
   import irq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  svc_mode_e         mode_q,
   input  logic              iack_n,
   input  logic              irq_n,
   input  logic [DATA_W-1:0] vec_q,
   output logic              bus_oe,
   output logic [DATA_W-1:0] bus_data
);
   assign bus_oe   = (mode_q == MODE_VECT) && !iack_n && !irq_n;
   assign bus_data = bus_oe ? vec_q : '0;
endmodule

// File: rtl/irq_front.sv
module irq_front
   import irq_pkg::*;
#(
   parameter int unsigned     DATA_W     = 8,
   parameter int unsigned     ADDR_W     = 3,
   parameter int unsigned     N_CH       = 2,
   parameter int unsigned     SRC_PER_CH = 4,
   parameter int unsigned     ERR_PER_CH = 3,
   parameter bit              REG_IRQ    = 1'b0,
   parameter logic [DATA_W-1:0] VEC_RST  = 8'h0F
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CH*SRC_PER_CH-1:0] src_pend,
   input  logic [N_CH*ERR_PER_CH-1:0] rx_err,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic                       iack_n,
   output logic                       irq_n,
   output logic [DATA_W-1:0]          bus_data,
   output logic                       bus_oe
);
   localparam int unsigned N_SRC = N_CH * SRC_PER_CH;
   localparam int unsigned ERR_LSB = DATA_W / 2;

   if (N_SRC > DATA_W) begin : g_chk_mask
      $error("irq_front: mask wider than data path");
   end
   if (SRC_PER_CH > ERR_LSB || ERR_PER_CH >= DATA_W - ERR_LSB) begin : g_chk_stat
      $error("irq_front: status fields do not fit");
   end
   if ((ADDR_STAT0 + N_CH) > (1 << ADDR_W)) begin : g_chk_addr
      $error("irq_front: address space too small");
   end

   logic [N_SRC-1:0]  mask_q;
   logic [DATA_W-1:0] vec_q;
   svc_mode_e         mode_q;

   irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SRC(N_SRC), .VEC_RST(VEC_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .mask_q  (mask_q),
      .vec_q   (vec_q),
      .mode_q  (mode_q)
   );

   irq_combine #(.N_SRC(N_SRC), .REG_IRQ(REG_IRQ)) u_comb (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_pend (src_pend),
      .mask_q   (mask_q),
      .irq_n    (irq_n)
   );

   irq_vec_drive #(.DATA_W(DATA_W)) u_drive (
      .mode_q   (mode_q),
      .iack_n   (iack_n),
      .irq_n    (irq_n),
      .vec_q    (vec_q),
      .bus_oe   (bus_oe),
      .bus_data (bus_data)
   );

   logic [DATA_W-1:0] stat [N_CH];
   for (genvar c = 0; c < N_CH; c++) begin : g_stat
      always_comb begin
         stat[c] = '0;
         stat[c][SRC_PER_CH-1:0]        = src_pend[c*SRC_PER_CH +: SRC_PER_CH];
         stat[c][ERR_LSB +: ERR_PER_CH] = rx_err[c*ERR_PER_CH +: ERR_PER_CH];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_MASK))      rd_data[N_SRC-1:0] = mask_q;
      else if (rd_addr == ADDR_W'(ADDR_VECT)) rd_data = vec_q;
      else if (rd_addr == ADDR_W'(ADDR_CMD))  rd_data[0] = (mode_q == MODE_VECT);
      for (int c = 0; c < N_CH; c++) begin
         if (rd_addr == ADDR_W'(ADDR_STAT0 + c)) rd_data = stat[c];
      end
   end

   assert_vector_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_VECT && !iack_n && !irq_n) |-> (bus_oe && bus_data == vec_q));

   assert_quiet_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_PLAIN || iack_n) |-> !bus_oe);

   if (!REG_IRQ) begin : g_irq_chk
      assert_masked_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ((src_pend & mask_q) == '0) |-> irq_n);
      assert_pending_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ((src_pend & mask_q) != '0) |-> !irq_n);
   end

   assert_err_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(rx_err) && $stable(src_pend) && $stable(mask_q)) |-> $stable(irq_n));
endmodule

// File: tb/irq_front_tb.sv
module irq_front_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_pend = '0;
   logic [5:0] rx_err = '0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       iack_n = 1'b1;
   logic       irq_n;
   logic [7:0] bus_data;
   logic       bus_oe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_front u_dut (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .rx_err(rx_err),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .iack_n(iack_n),
      .irq_n(irq_n), .bus_data(bus_data), .bus_oe(bus_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic t_reset;
      #1;
      chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
      chk("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
      rd_chk("R1 mask", 3'd0, 8'h00);
      rd_chk("R1 vector", 3'd1, 8'h0F);
      rd_chk("R1 mode", 3'd2, 8'h00);
   endtask

   task automatic t_mask;
      src_pend = 8'h01; #1;
      chk("R5 masked source", {7'b0, irq_n}, 8'h01);
      wr(3'd0, 8'h01);
      chk("R5 enabled source", {7'b0, irq_n}, 8'h00);
      rd_chk("R6 mask readback", 3'd0, 8'h01);
      src_pend = 8'h02; #1;
      chk("R5 other source masked", {7'b0, irq_n}, 8'h01);
      wr(3'd0, 8'h80);
      src_pend = 8'h81; #1;
      chk("R5 channel B source", {7'b0, irq_n}, 8'h00);
      src_pend = 8'h00; #1;
      chk("R5 cleared", {7'b0, irq_n}, 8'h01);
   endtask

   task automatic t_mask_timing;
      src_pend = 8'h10;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10;
      #1;
      chk("R6 before edge", {7'b0, irq_n}, 8'h01);
      @(posedge clk); #1;
      chk("R6 after edge", {7'b0, irq_n}, 8'h00);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_plain_ack;
      iack_n = 1'b0; #1;
      chk("R4 plain ack no drive", {7'b0, bus_oe}, 8'h00);
      chk("R4 request stays without ack", {7'b0, irq_n}, 8'h00);
      iack_n = 1'b1; #1;
   endtask

   task automatic t_vector_rw;
      wr(3'd1, 8'hA5);
      rd_chk("R7 vector readback", 3'd1, 8'hA5);
   endtask

   task automatic t_bad_cmd;
      wr(3'd2, 8'h7E);
      rd_chk("R8 bad command mode", 3'd2, 8'h00);
      iack_n = 1'b0; #1;
      chk("R8 bad command no drive", {7'b0, bus_oe}, 8'h00);
      iack_n = 1'b1; #1;
   endtask

   task automatic t_vect;
      wr(3'd2, 8'h01);
      rd_chk("R2 mode set", 3'd2, 8'h01);
      chk("R4 no ack no drive", {7'b0, bus_oe}, 8'h00);
      iack_n = 1'b0; #1;
      chk("R3 drive enable", {7'b0, bus_oe}, 8'h01);
      chk("R3 vector on bus", bus_data, 8'hA5);
      src_pend = 8'h00; #1;
      chk("R4 no request no drive", {7'b0, bus_oe}, 8'h00);
      src_pend = 8'h10; iack_n = 1'b1; #1;
   endtask

   task automatic t_revert;
      wr(3'd2, 8'h02);
      rd_chk("R8 plain again", 3'd2, 8'h00);
      rd_chk("R8 mask kept", 3'd0, 8'h10);
      rd_chk("R8 vector kept", 3'd1, 8'hA5);
      iack_n = 1'b0; #1;
      chk("R8 no drive after revert", {7'b0, bus_oe}, 8'h00);
      iack_n = 1'b1; #1;
   endtask

   task automatic t_err;
      wr(3'd0, 8'hFF);
      src_pend = 8'h00; #1;
      rx_err = 6'h3F; #1;
      @(negedge clk); #1;
      chk("R9 errors no request", {7'b0, irq_n}, 8'h01);
      rd_chk("R9 status A all errors", 3'd3, 8'h70);
      src_pend = 8'h35; rx_err = 6'b010_101; #1;
      rd_chk("R9 status A", 3'd3, 8'h55);
      rd_chk("R9 status B", 3'd4, 8'h23);
      rd_chk("R10 unused address", 3'd6, 8'h00);
      rx_err = 6'h00; src_pend = 8'h00; #1;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_mask();
      t_mask_timing();
      t_plain_ack();
      t_vector_rw();
      t_bad_cmd();
      t_vect();
      t_revert();
      t_err();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule